// File: doc/BRIEF.md
# Inbound Vendor Message Filter

This block sits at the head of an inbound posted queue. Each entry of the queue carries a data word and a flag that marks it as a vendor-defined message. Ordinary entries go straight through to the output stream. A vendor message is taken into a single holding register whenever that register is empty. The capture sets a full flag and raises an interrupt, and software later frees the register with a release pulse.

When a vendor message reaches the head while the holding register is still occupied, a configuration bit decides what happens. With drop mode on, which is the reset state, the message is accepted and thrown away, and a saturating counter records the loss. With drop mode off, the message waits at the head and stalls every entry behind it until software frees the register. Drop mode avoids a deadlock in which the processor is waiting on a read completion that sits behind an unserviced message.

Top module: `vmsg_filter`

## Requirements
- R1: After reset, drop_en is 1, hold_full is 0, hold_irq is 0 and drop_cnt is 0.
- R2: An entry with in_vdm=0 is passed on combinationally: out_valid equals in_valid, out_data equals in_data, and in_ready equals out_ready.
- R3: A vendor entry (in_valid=1, in_vdm=1) that arrives while hold_full=0 is accepted (in_ready=1). On the next cycle hold_full is 1 and hold_data holds its data word.
- R4: In the default pulse variant, hold_irq is high for exactly the one cycle after a capture and low otherwise.
- R5: A hold_release pulse while hold_full=1 clears hold_full on the next cycle. A release while the register is empty has no effect. A vendor entry that arrives in the same cycle as the release is still handled as if the register were full.
- R6: With drop_en=1, a vendor entry that arrives while hold_full=1 is accepted and discarded. hold_data does not change, and drop_cnt increases by one.
- R7: With drop_en=0, a vendor entry that arrives while hold_full=1 keeps in_ready at 0, so it and all traffic behind it stay in place. It is captured once the register has been released.
- R8: drop_cnt saturates at 2^CNT_W-1, and further drops leave it unchanged.
- R9: cfg_wr=1 loads cfg_drop_en into drop_en, which is visible on the next cycle.
- R10: out_valid is never 1 while the head entry is a vendor message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Queue head holds an entry |
| in_vdm | input | 1 | Head entry is a vendor-defined message |
| in_data | input | DATA_W | Head entry data word |
| in_ready | output | 1 | Head entry is consumed this cycle |
| out_valid | output | 1 | Output stream entry present |
| out_ready | input | 1 | Downstream accepts the output entry |
| out_data | output | DATA_W | Output stream data word |
| hold_release | input | 1 | Software frees the holding register |
| hold_full | output | 1 | Holding register occupied |
| hold_data | output | DATA_W | Captured message word |
| hold_irq | output | 1 | Message interrupt |
| cfg_wr | input | 1 | Write strobe for the drop-mode bit |
| cfg_drop_en | input | 1 | New value of the drop-mode bit |
| drop_en | output | 1 | Current drop-mode bit |
| drop_cnt | output | CNT_W | Saturating count of discarded messages |

## Verification
The assertions check the per-cycle rules on every clock: ordinary entries pass through unchanged, vendor messages never reach the output, a stalled head is never consumed, and each capture, release, drop, counter step and configuration write has its one-cycle effect. Other properties appear only over longer sequences and are shown by the bench scenarios. These are the counter reaching its ceiling and staying there, the stalled message being captured once software has released the register, a release that lands in the same cycle as a blocked message, and traffic resuming after the stall.

// File: rtl/vmsg_pkg.sv
package vmsg_pkg;
   typedef enum logic [2:0] {
      RT_IDLE  = 3'd0,
      RT_PASS  = 3'd1,
      RT_CAPT  = 3'd2,
      RT_DROP  = 3'd3,
      RT_STALL = 3'd4
   } route_e;
endpackage

// File: rtl/vmsg_route.sv
module vmsg_route
   import vmsg_pkg::*;
(
   input  logic   in_valid,
   input  logic   in_vdm,
   input  logic   out_ready,
   input  logic   hold_full,
   input  logic   drop_en,
   output route_e route,
   output logic   in_ready,
   output logic   out_valid
);
   always_comb begin
      if (!in_valid)       route = RT_IDLE;
      else if (!in_vdm)    route = RT_PASS;
      else if (!hold_full) route = RT_CAPT;
      else if (drop_en)    route = RT_DROP;
      else                 route = RT_STALL;
   end

   assign in_ready  = in_vdm ? (!hold_full || drop_en) : out_ready;
   assign out_valid = (route == RT_PASS);
endmodule

// File: rtl/vmsg_hold.sv
module vmsg_hold #(
   parameter int DATA_W    = 32,
   parameter bit IRQ_PULSE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic              release_i,
   input  logic [DATA_W-1:0] cap_data,
   output logic              full,
   output logic [DATA_W-1:0] data,
   output logic              irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         data <= '0;
      end else if (capture) begin
         full <= 1'b1;
         data <= cap_data;
      end else if (release_i) begin
         full <= 1'b0;
      end
   end

   generate
      if (IRQ_PULSE) begin : g_pulse
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= capture;
         end
         assign irq = irq_q;
      end else begin : g_level
         assign irq = full;
      end
   endgenerate
endmodule

// File: rtl/vmsg_sat_ctr.sv
module vmsg_sat_ctr #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] MAX = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   count <= '0;
      else if (inc && count != MAX) count <= count + 1'b1;
   end
endmodule

// File: rtl/vmsg_filter.sv
module vmsg_filter
   import vmsg_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 8,
   parameter bit IRQ_PULSE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_vdm,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   input  logic              hold_release,
   output logic              hold_full,
   output logic [DATA_W-1:0] hold_data,
   output logic              hold_irq,
   input  logic              cfg_wr,
   input  logic              cfg_drop_en,
   output logic              drop_en,
   output logic [CNT_W-1:0]  drop_cnt
);
   generate
      if (DATA_W < 1) begin : g_bad_data_w
         $error("vmsg_filter: DATA_W must be at least 1");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt_w
         $error("vmsg_filter: CNT_W must be in 1..32");
      end
   endgenerate

   route_e route;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      drop_en <= 1'b1;
      else if (cfg_wr) drop_en <= cfg_drop_en;
   end

   vmsg_route u_route (
      .in_valid  (in_valid),
      .in_vdm    (in_vdm),
      .out_ready (out_ready),
      .hold_full (hold_full),
      .drop_en   (drop_en),
      .route     (route),
      .in_ready  (in_ready),
      .out_valid (out_valid)
   );

   assign out_data = in_data;

   vmsg_hold #(.DATA_W(DATA_W), .IRQ_PULSE(IRQ_PULSE)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (route == RT_CAPT),
      .release_i (hold_release),
      .cap_data  (in_data),
      .full      (hold_full),
      .data      (hold_data),
      .irq       (hold_irq)
   );

   vmsg_sat_ctr #(.W(CNT_W)) u_drop_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (route == RT_DROP),
      .count (drop_cnt)
   );
endmodule

// File: rtl/vmsg_filter_chk.sv
module vmsg_filter_chk #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_vdm,
   input logic [DATA_W-1:0] in_data,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_data,
   input logic              hold_release,
   input logic              hold_full,
   input logic [DATA_W-1:0] hold_data,
   input logic              hold_irq,
   input logic              cfg_wr,
   input logic              cfg_drop_en,
   input logic              drop_en,
   input logic [CNT_W-1:0]  drop_cnt
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   logic vdm_head;
   assign vdm_head = in_valid && in_vdm;

   a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !in_vdm |-> out_valid && out_data == in_data && in_ready == out_ready);

   a_r10_no_vendor_out: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_vdm);

   a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
      vdm_head && !hold_full |=> hold_full && hold_data == $past(in_data));

   a_r4_irq_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
      vdm_head && !hold_full |=> hold_irq);

   a_r4_irq_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      hold_irq |-> hold_full);

   a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
      hold_release && hold_full |=> !hold_full);

   a_r6_drop_accept: assert property (@(posedge clk) disable iff (!rst_n)
      vdm_head && hold_full && drop_en |-> in_ready);

   a_r6_drop_keeps_hold: assert property (@(posedge clk) disable iff (!rst_n)
      vdm_head && hold_full && drop_en |=> hold_data == $past(hold_data));

   a_r6_drop_count: assert property (@(posedge clk) disable iff (!rst_n)
      vdm_head && hold_full && drop_en && drop_cnt != CMAX
      |=> drop_cnt == CNT_W'($past(drop_cnt) + 1'b1));

   a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      drop_cnt == CMAX |=> drop_cnt == CMAX);

   a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
      vdm_head && hold_full && !drop_en |-> !in_ready && !out_valid);

   a_r9_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> drop_en == $past(cfg_drop_en));
endmodule

bind vmsg_filter vmsg_filter_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .in_vdm       (in_vdm),
   .in_data      (in_data),
   .in_ready     (in_ready),
   .out_valid    (out_valid),
   .out_ready    (out_ready),
   .out_data     (out_data),
   .hold_release (hold_release),
   .hold_full    (hold_full),
   .hold_data    (hold_data),
   .hold_irq     (hold_irq),
   .cfg_wr       (cfg_wr),
   .cfg_drop_en  (cfg_drop_en),
   .drop_en      (drop_en),
   .drop_cnt     (drop_cnt)
);

// File: tb/vmsg_filter_bench.sv
`timescale 1ns/1ps
module vmsg_filter_bench;
   localparam int DW   = 32;
   localparam int CW   = 3;
   localparam int CMAX = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          in_valid, in_vdm, out_ready, hold_release, cfg_wr, cfg_drop_en;
   logic [DW-1:0] in_data;
   logic          in_ready, out_valid, hold_full, hold_irq, drop_en;
   logic [DW-1:0] out_data, hold_data;
   logic [CW-1:0] drop_cnt;

   int checks = 0;
   int errors = 0;

   // reference model state
   bit          m_full;
   logic [DW-1:0] m_hold;
   bit          m_irq;
   int          m_cnt;
   bit          m_den;

   always #2.5 clk = ~clk;

   vmsg_filter #(.DATA_W(DW), .CNT_W(CW)) u_vmsg_filter (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_vdm(in_vdm), .in_data(in_data), .in_ready(in_ready),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .hold_release(hold_release), .hold_full(hold_full), .hold_data(hold_data),
      .hold_irq(hold_irq), .cfg_wr(cfg_wr), .cfg_drop_en(cfg_drop_en),
      .drop_en(drop_en), .drop_cnt(drop_cnt)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input logic v, input logic vdm, input logic [DW-1:0] d,
                       input logic ordy, input logic rel, input logic cw, input logic cwd);
      bit cap, drp, e_rdy, e_ov;
      @(negedge clk);
      in_valid = v; in_vdm = vdm; in_data = d; out_ready = ordy;
      hold_release = rel; cfg_wr = cw; cfg_drop_en = cwd;
      #1;
      e_rdy = vdm ? (!m_full || m_den) : ordy;
      e_ov  = v && !vdm;
      chk(in_ready === e_rdy, vdm ? "R7 in_ready" : "R2 in_ready", in_ready, e_rdy);
      chk(out_valid === e_ov, "R10 out_valid", out_valid, e_ov);
      if (e_ov) chk(out_data === d, "R2 out_data", out_data, d);
      chk(hold_full === m_full, "R5 hold_full", hold_full, m_full);
      chk(hold_data === m_hold, "R3 hold_data", hold_data, m_hold);
      chk(hold_irq === m_irq, "R4 hold_irq", hold_irq, m_irq);
      chk(int'(drop_cnt) == m_cnt, (m_cnt == CMAX) ? "R8 drop_cnt" : "R6 drop_cnt",
          drop_cnt, m_cnt);
      chk(drop_en === m_den, "R9 drop_en", drop_en, m_den);
      // advance the model to the state after the coming edge
      cap = v && vdm && !m_full;
      drp = v && vdm && m_full && m_den;
      m_irq = cap;
      if (cap) begin
         m_full = 1'b1;
         m_hold = d;
      end else if (rel) begin
         m_full = 1'b0;
      end
      if (drp && m_cnt < CMAX) m_cnt++;
      if (cw) m_den = cwd;
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      in_valid = 0; in_vdm = 0; in_data = '0; out_ready = 0;
      hold_release = 0; cfg_wr = 0; cfg_drop_en = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk(drop_en === 1'b1, "R1 drop_en", drop_en, 1);
      chk(hold_full === 1'b0, "R1 hold_full", hold_full, 0);
      chk(hold_irq === 1'b0, "R1 hold_irq", hold_irq, 0);
      chk(drop_cnt === '0, "R1 drop_cnt", drop_cnt, 0);
      m_full = 0; m_hold = '0; m_irq = 0; m_cnt = 0; m_den = 1;

      // R2 ordinary traffic with varying readiness
      for (int i = 0; i < 8; i++)
         step(i % 3 != 2, 1'b0, 32'hA000_0000 + i * 32'h111, i[0], 1'b0, 1'b0, 1'b0);

      // R3/R4 capture into empty register, then idle
      step(1, 1, 32'hCAFE_0001, 1, 0, 0, 0);
      step(0, 0, 32'h0, 1, 0, 0, 0);

      // R6/R8 drop mode: more vendor messages than the counter can hold
      for (int i = 0; i < 10; i++) begin
         step(1, 1, 32'hD000_0000 + i, 1, 0, 0, 0);
         step(1, 0, 32'h5000_0000 + i, 1, 0, 0, 0);
      end

      // R5 release, then release while empty
      step(0, 0, 32'h0, 1, 1, 0, 0);
      step(0, 0, 32'h0, 1, 1, 0, 0);
      step(1, 0, 32'h1234_5678, 0, 0, 0, 0);

      // R9 switch to blocking mode
      step(0, 0, 32'h0, 1, 0, 1, 0);
      // R7 capture one message, then a second one stalls the head
      step(1, 1, 32'hB000_0001, 1, 0, 0, 0);
      for (int i = 0; i < 4; i++)
         step(1, 1, 32'hB000_0002, 1, 0, 0, 0);
      // release in the same cycle as the blocked head (R5), then capture
      step(1, 1, 32'hB000_0002, 1, 1, 0, 0);
      step(1, 1, 32'hB000_0002, 1, 0, 0, 0);
      step(1, 0, 32'h7777_0000, 1, 0, 0, 0);
      step(0, 0, 32'h0, 1, 1, 0, 0);

      // R9 back to drop mode; R8 counter stays at its ceiling
      step(0, 0, 32'h0, 1, 0, 1, 1);
      step(1, 1, 32'hE000_0001, 1, 0, 0, 0);
      step(1, 1, 32'hE000_0002, 1, 0, 0, 0);
      step(0, 0, 32'h0, 1, 0, 0, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule